// File: doc/BRIEF.md
# Potentiometer Wiper Register File and Instruction Executor

This block holds the tap settings for four digitally controlled potentiometers and carries out the instructions that a serial bus front end has already framed into bytes. Each potentiometer owns a 6-bit volatile wiper register, which drives its wiper code output, and four 6-bit nonvolatile data registers. The nonvolatile registers are modelled as flops behind a write-cycle timer. The front end presents the instruction byte, an optional third (data) byte, increment/decrement clock pulses and the stop condition, each as a single-cycle strobe. The block returns an acknowledge for every instruction it accepts and a read byte for the read instructions.

An instruction byte carries the opcode in bits 7:4, the potentiometer select in bits 3:2 and the data register select in bits 1:0. Some instructions move data between the host and one register. Others move data between a wiper register and a data register, either for one potentiometer or for all four at once with the same register index. Writes that reach the wiper register take effect at once. Writes that reach a data register are held until the stop condition, and then start a write cycle during which `busy` is high and every new instruction is refused.

Top module: `wiper_regfile`

## Requirements
- R1: Reset is the power-up event. Data register r of potentiometer p is reloaded from the stored image value (16*p + 5*r + 3) mod 64, and each wiper register takes the value of its own data register 0. After reset, `busy` is 0 and `rd_data` is 0.
- R2: The legal opcodes are 1001, 1010, 1011, 1100, 1101, 1110, 0001, 1000 and 0010. An instruction with any other opcode gets no acknowledge. Data bytes, steps and the stop condition that follow it change no register, and `busy` stays low.
- R3: Opcode 1010 (write wiper): the data byte that follows sets the selected wiper to the byte's six low bits one cycle after the data strobe. The other wipers do not change.
- R4: Opcode 1001 (read wiper) and opcode 1011 (read data register) put the selected 6-bit value on `rd_data`, with bits 7:6 zero, one cycle after the instruction strobe.
- R5: Opcode 1101 copies data register R of the selected potentiometer into that potentiometer's wiper one cycle after the instruction strobe. The other wipers do not change.
- R6: Opcode 0001 copies data register R into the wiper of every potentiometer one cycle after the instruction strobe.
- R7: Opcode 1100 (write data register) stores the six low bits of the data byte into the selected data register only at the stop condition. `busy` rises one cycle after the stop strobe and stays high for exactly WR_CYCLES cycles.
- R8: Opcode 1110 copies the selected wiper into its data register R at the stop condition. Opcode 1000 does the same for all four potentiometers with the same index R. Each starts the same busy window as R7.
- R9: While `busy` is high, `cmd_ack` stays low and no instruction, data byte or step changes any register or any wiper output.
- R10: Opcode 0010 (increment/decrement): each step strobe moves the selected wiper by one, upward when `step_up` is 1 and downward when it is 0. The wiper saturates at 63 and at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset; acts as power-up recall |
| cmd_valid | input | 1 | Instruction byte strobe |
| cmd_byte | input | 8 | Instruction byte: opcode[7:4], pot select[3:2], register select[1:0] |
| data_valid | input | 1 | Third-byte strobe |
| data_byte | input | 8 | Third byte from the host |
| step_valid | input | 1 | Increment/decrement step strobe |
| step_up | input | 1 | Step direction: 1 toward the top code, 0 toward zero |
| stop | input | 1 | Stop condition strobe |
| cmd_ack | output | 1 | Instruction accepted (combinational with cmd_valid) |
| rd_data | output | 8 | Read result, zero-extended from 6 bits |
| busy | output | 1 | Nonvolatile write cycle in progress |
| wipers | output | 24 | Four 6-bit wiper codes, potentiometer p in bits 6p+5:6p |

## Verification
A corrupted wiper register appears on `wipers` in the cycle after the instruction or step that wrote it, so each wiper and each step is checked on the next falling edge. A wrong data register stays hidden until it is read back or copied into a wiper. For that reason every data register is swept through read instructions after each write, each single transfer and each global transfer. A timer fault shows as a busy window of the wrong length, or as an instruction that is acknowledged during the window, and the window is counted cycle by cycle.

// File: rtl/wiper_regfile.sv
module wiper_regfile #(
  parameter int W = 6,
  parameter int WR_CYCLES = 20
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cmd_valid,
  input  logic [7:0]     cmd_byte,
  input  logic           data_valid,
  input  logic [7:0]     data_byte,
  input  logic           step_valid,
  input  logic           step_up,
  input  logic           stop,
  output logic           cmd_ack,
  output logic [7:0]     rd_data,
  output logic           busy,
  output logic [4*W-1:0] wipers
);
  localparam int NP = 4;
  localparam int NR = 4;
  localparam int CW = $clog2(WR_CYCLES) + 1;
  localparam logic [W-1:0] TOP = {W{1'b1}};

  localparam logic [3:0] OP_RWCR  = 4'b1001;
  localparam logic [3:0] OP_WWCR  = 4'b1010;
  localparam logic [3:0] OP_RDR   = 4'b1011;
  localparam logic [3:0] OP_WDR   = 4'b1100;
  localparam logic [3:0] OP_D2W   = 4'b1101;
  localparam logic [3:0] OP_W2D   = 4'b1110;
  localparam logic [3:0] OP_GD2W  = 4'b0001;
  localparam logic [3:0] OP_GW2D  = 4'b1000;
  localparam logic [3:0] OP_STEP  = 4'b0010;

  function automatic logic [W-1:0] image(int p, int r);
    return W'((16 * p + 5 * r + 3) % 64);
  endfunction

  logic [W-1:0] wcr [NP];
  logic [W-1:0] dr  [NP][NR];
  logic         active, nv_pend;
  logic [3:0]   op;
  logic [1:0]   psel, rsel;
  logic [W-1:0] nv_data;
  logic [CW-1:0] cnt;

  wire [3:0] new_op = cmd_byte[7:4];
  wire op_legal = (new_op == OP_RWCR) || (new_op == OP_WWCR) || (new_op == OP_RDR) ||
                  (new_op == OP_WDR)  || (new_op == OP_D2W)  || (new_op == OP_W2D) ||
                  (new_op == OP_GD2W) || (new_op == OP_GW2D) || (new_op == OP_STEP);

  assign cmd_ack = cmd_valid & ~busy & op_legal;

  wire wr_wcr  = active && op == OP_WWCR && data_valid;
  wire cap_dr  = active && op == OP_WDR  && data_valid;
  wire do_step = active && op == OP_STEP && step_valid;
  wire commit  = stop && nv_pend;

  wire [W-1:0] sel_wiper = wcr[psel];

  genvar g;
  generate
    for (g = 0; g < NP; g++) begin : g_out
      assign wipers[g*W +: W] = wcr[g];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < NP; p++) begin
        wcr[p] <= image(p, 0);
        for (int r = 0; r < NR; r++) dr[p][r] <= image(p, r);
      end
      active  <= 1'b0;
      nv_pend <= 1'b0;
      op      <= '0;
      psel    <= '0;
      rsel    <= '0;
      nv_data <= '0;
      busy    <= 1'b0;
      cnt     <= '0;
      rd_data <= '0;
    end else begin
      if (stop) begin
        active  <= 1'b0;
        nv_pend <= 1'b0;
      end

      if (commit) begin
        busy <= 1'b1;
        cnt  <= CW'(WR_CYCLES - 1);
        case (op)
          OP_WDR:  dr[psel][rsel] <= nv_data;
          OP_W2D:  dr[psel][rsel] <= wcr[psel];
          OP_GW2D: for (int p = 0; p < NP; p++) dr[p][rsel] <= wcr[p];
          default: ;
        endcase
      end else if (busy) begin
        if (cnt == '0) busy <= 1'b0;
        else cnt <= cnt - 1'b1;
      end

      if (cmd_ack) begin
        active  <= 1'b1;
        op      <= new_op;
        psel    <= cmd_byte[3:2];
        rsel    <= cmd_byte[1:0];
        nv_pend <= (new_op == OP_W2D) || (new_op == OP_GW2D);
        case (new_op)
          OP_RWCR: rd_data <= 8'(wcr[cmd_byte[3:2]]);
          OP_RDR:  rd_data <= 8'(dr[cmd_byte[3:2]][cmd_byte[1:0]]);
          OP_D2W:  wcr[cmd_byte[3:2]] <= dr[cmd_byte[3:2]][cmd_byte[1:0]];
          OP_GD2W: for (int p = 0; p < NP; p++) wcr[p] <= dr[p][cmd_byte[1:0]];
          default: ;
        endcase
      end

      if (wr_wcr) wcr[psel] <= data_byte[W-1:0];

      if (cap_dr) begin
        nv_data <= data_byte[W-1:0];
        nv_pend <= 1'b1;
      end

      if (do_step) begin
        if (step_up && sel_wiper != TOP) wcr[psel] <= sel_wiper + 1'b1;
        else if (!step_up && sel_wiper != '0) wcr[psel] <= sel_wiper - 1'b1;
      end
    end
  end

  // R9: no register reaches the outputs while a write cycle runs
  a_r9_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(wipers));

  // R7: write window opens only from a stop condition
  a_r7_busy_from_stop: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stop));

  // R3: direct wiper write lands on the selected wiper
  a_r3_wcr_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_wcr && !cmd_valid) |=> sel_wiper == $past(data_byte[W-1:0]));

  // R10: upward step moves exactly one code
  a_r10_step_up: assert property (@(posedge clk) disable iff (!rst_n)
    (do_step && step_up && sel_wiper != TOP && !cmd_valid) |=> sel_wiper == $past(sel_wiper) + 1'b1);

  // R10: saturation at both ends
  a_r10_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (do_step && !cmd_valid && ((step_up && sel_wiper == TOP) || (!step_up && sel_wiper == '0)))
      |=> $stable(sel_wiper));

  // R4: read byte never carries bits above the register width
  a_r4_read_pad: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cmd_ack) |-> rd_data[7:W] == '0);
endmodule

// File: tb/tb_wiper_regfile.sv
module tb_wiper_regfile;
  localparam int CLK_P = 10;
  localparam int W = 6;
  localparam int WRC = 20;

  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0, data_valid = 0, step_valid = 0, step_up = 0, stop = 0;
  logic [7:0] cmd_byte = 0, data_byte = 0;
  logic cmd_ack, busy;
  logic [7:0] rd_data;
  logic [4*W-1:0] wipers;

  int n_cmp = 0, n_bad = 0;
  int wcr_m [4];
  int dr_m [4][4];

  wiper_regfile #(.W(W), .WR_CYCLES(WRC)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
    .data_valid(data_valid), .data_byte(data_byte), .step_valid(step_valid),
    .step_up(step_up), .stop(stop), .cmd_ack(cmd_ack), .rd_data(rd_data),
    .busy(busy), .wipers(wipers));

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic chk_wipers(input string tag);
    for (int p = 0; p < 4; p++) chk(tag, int'(wipers[p*W +: W]), wcr_m[p]);
  endtask

  task automatic do_cmd(input int op, input int p, input int r, output logic ack);
    @(negedge clk);
    cmd_valid = 1; cmd_byte = 8'((op << 4) | (p << 2) | r);
    #1 ack = cmd_ack;
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic do_data(input int b);
    @(negedge clk); data_valid = 1; data_byte = 8'(b);
    @(negedge clk); data_valid = 0;
  endtask

  task automatic do_stop();
    @(negedge clk); stop = 1;
    @(negedge clk); stop = 0;
  endtask

  task automatic do_step(input logic up);
    @(negedge clk); step_valid = 1; step_up = up;
    @(negedge clk); step_valid = 0;
  endtask

  task automatic busy_len(input string tag);
    int n = 0;
    while (busy && n < 1000) begin n++; @(negedge clk); end
    chk(tag, n, WRC);
  endtask

  task automatic drain();
    int n = 0;
    while (busy && n < 1000) begin n++; @(negedge clk); end
  endtask

  task automatic read_all(input string tag);
    logic a;
    for (int p = 0; p < 4; p++) begin
      for (int r = 0; r < 4; r++) begin
        do_cmd(4'b1011, p, r, a);
        chk({tag, " ack"}, a, 1);
        chk(tag, rd_data, dr_m[p][r]);
        do_stop();
      end
      do_cmd(4'b1001, p, 0, a);
      chk(tag, rd_data, wcr_m[p]);
      do_stop();
    end
  endtask

  initial begin
    #(CLK_P * 20000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic a;
    for (int p = 0; p < 4; p++) begin
      for (int r = 0; r < 4; r++) dr_m[p][r] = (16 * p + 5 * r + 3) % 64;
      wcr_m[p] = dr_m[p][0];
    end
    #(CLK_P * 3); rst_n = 1;
    @(negedge clk);
    // R1 power-up recall
    chk_wipers("R1 wipers");
    chk("R1 busy", busy, 0);
    chk("R1 rd_data", rd_data, 0);
    // R4 read all registers at power-up
    read_all("R4 readback");

    // R3 direct wiper writes, upper bits dropped
    for (int p = 0; p < 4; p++) begin
      int vals [3] = '{8'hFF, 8'h40 + p, 8'h15 + 9 * p};
      foreach (vals[k]) begin
        do_cmd(4'b1010, p, 0, a);
        chk("R3 ack", a, 1);
        do_data(vals[k]);
        wcr_m[p] = vals[k] % 64;
        chk_wipers("R3 wipers");
        do_stop();
        chk("R3 no busy", busy, 0);
      end
    end

    // R7 write every data register, commit at stop
    for (int p = 0; p < 4; p++)
      for (int r = 0; r < 4; r++) begin
        int v = 8'hC0 | ((7 * p + 11 * r + 40) % 64);
        do_cmd(4'b1100, p, r, a);
        chk("R7 ack", a, 1);
        do_data(v);
        chk("R7 no busy before stop", busy, 0);
        do_stop();
        dr_m[p][r] = v % 64;
        busy_len("R7 busy window");
      end
    read_all("R7 readback");

    // R9 instructions refused during the write window
    do_cmd(4'b1100, 2, 1, a);
    do_data(8'h2A);
    do_stop();
    dr_m[2][1] = 8'h2A;
    chk("R9 busy", busy, 1);
    do_cmd(4'b1010, 0, 0, a);
    chk("R9 ack low", a, 0);
    do_data(8'h01);
    chk_wipers("R9 wipers");
    do_cmd(4'b0001, 0, 3, a);
    chk("R9 global refused", a, 0);
    chk_wipers("R9 wipers");
    do_stop();
    drain();
    read_all("R9 readback");

    // R5 single transfer data register to wiper
    for (int p = 0; p < 4; p++) begin
      int r = (p + 1) % 4;
      do_cmd(4'b1101, p, r, a);
      chk("R5 ack", a, 1);
      wcr_m[p] = dr_m[p][r];
      chk_wipers("R5 wipers");
      do_stop();
      chk("R5 no busy", busy, 0);
    end

    // R6 global transfer for each register index
    for (int r = 0; r < 4; r++) begin
      do_cmd(4'b0001, 1, r, a);
      chk("R6 ack", a, 1);
      for (int p = 0; p < 4; p++) wcr_m[p] = dr_m[p][r];
      chk_wipers("R6 wipers");
      do_stop();
    end

    // R8 single wiper to data register
    for (int p = 0; p < 4; p++) begin
      do_cmd(4'b1010, p, 0, a);
      do_data(50 - 3 * p);
      wcr_m[p] = 50 - 3 * p;
      do_stop();
      do_cmd(4'b1110, p, 3 - p, a);
      chk("R8 ack", a, 1);
      do_stop();
      dr_m[p][3 - p] = wcr_m[p];
      busy_len("R8 busy window");
    end
    // R8 global wiper to data register index 2
    for (int p = 0; p < 4; p++) begin
      do_cmd(4'b1010, p, 0, a);
      do_data(5 + 13 * p);
      wcr_m[p] = 5 + 13 * p;
      do_stop();
    end
    do_cmd(4'b1000, 0, 2, a);
    chk("R8 global ack", a, 1);
    do_stop();
    for (int p = 0; p < 4; p++) dr_m[p][2] = wcr_m[p];
    busy_len("R8 global busy window");
    read_all("R8 readback");

    // R2 illegal opcodes ignored
    for (int op = 0; op < 16; op++) begin
      if (!(op inside {1, 2, 8, 9, 10, 11, 12, 13, 14})) begin
        do_cmd(op, 3, 1, a);
        chk("R2 no ack", a, 0);
        do_data(8'h3C);
        do_step(1);
        do_stop();
        chk("R2 no busy", busy, 0);
        chk_wipers("R2 wipers");
      end
    end
    read_all("R2 readback");

    // R10 increment/decrement with saturation
    do_cmd(4'b1010, 1, 0, a);
    do_data(60);
    wcr_m[1] = 60;
    do_stop();
    do_cmd(4'b0010, 1, 0, a);
    chk("R10 ack", a, 1);
    for (int i = 0; i < 5; i++) begin
      do_step(1);
      if (wcr_m[1] < 63) wcr_m[1]++;
      chk_wipers("R10 up");
    end
    for (int i = 0; i < 70; i++) begin
      do_step(0);
      if (wcr_m[1] > 0) wcr_m[1]--;
      chk_wipers("R10 down");
    end
    do_step(1);
    wcr_m[1]++;
    chk_wipers("R10 up from zero");
    do_stop();
    do_step(1);
    chk_wipers("R10 step after stop");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule